// File: doc/BRIEF.md
# Ethernet Receive Destination-Address Filter

The block watches the first six bytes of each received Ethernet frame, which carry the 48-bit destination address. From them it decides whether the frame should be kept. Bytes arrive one per valid cycle, and a start-of-frame pulse marks the first byte. One cycle after the sixth byte the block raises a one-cycle verdict strobe, together with an accept flag.

Several checks feed the decision:
- an exact compare against a bank of up to 16 enabled unicast address slots;
- a 64-bin multicast hash table, indexed by six bits derived from a CRC-32 of the address;
- a broadcast rule;
- override modes that accept everything, or every multicast frame.

A configuration port loads the mode bits, the hash words, the slot enables and the slot addresses. The mode bits, the hash table and the slot enables are captured when each frame's first byte is taken. A write that lands mid-frame therefore affects only the frames that follow.

Top module: `rx_addr_filter`

## Requirements
- R1: The hash index is computed as follows. A reflected CRC-32 (polynomial 0xEDB88320, preset all ones, least-significant bit first) runs over the six address bytes. The result is complemented and bit-reversed, and its top six bits form the index. Index bit 5 chooses the hash word: 1 selects the high word (cfg address 2) and 0 selects the low word (cfg address 1). Index bits 4..0 pick the bit within that word.
- R2: When mode bit 2 (hash multicast) is set and no higher rule decides, a multicast frame is accepted exactly when its indexed hash bit is 1.
- R3: When mode bit 1 (pass all multicast) is set, every multicast frame that is not a disabled broadcast is accepted, whatever the hash table holds.
- R4: When mode bit 0 (promiscuous) is set, every frame is accepted.
- R5: Unicast frame acceptance follows the slot bank.
  - A unicast frame is accepted when its address equals an enabled slot and is rejected otherwise.
  - Slot k's low word is at cfg address 32+2k and holds the first four received bytes, with the first byte in bits 7..0.
  - Slot k's high word is at cfg address 33+2k, and its bits 15..0 hold bytes five and six.
  - The slot enables are the bits of cfg address 3, bit k for slot k.
- R6: When mode bit 4 (receive all) is set, every frame is accepted.
- R7: An all-ones destination address is accepted unless mode bit 3 (broadcast disable) is set. With bit 3 set, the broadcast frame is rejected unless R4 or R6 applies.
- R8: A frame is multicast when bit 0 of its first byte is 1. A non-broadcast multicast frame is rejected when neither mode bit 1 nor mode bit 2 is set.
- R9: The verdict behaves as follows.
  - `verdict_vld` is high for exactly one cycle, registered at the clock edge that takes the sixth byte.
  - Each frame gives at most one verdict.
  - Bytes after the sixth are ignored.
- R10: The mode bits, the hash words and the slot enables are latched when a frame's first byte is taken. Writes to them during the frame do not change that frame's verdict.
- R11: Framing is controlled by `sof`.
  - A `sof` pulse with a valid byte restarts the CRC and the byte count.
  - A frame cut short by a new `sof` before its sixth byte yields no verdict.
  - Valid bytes seen with no open frame are ignored.
- R12: After reset, no verdict is produced until a frame arrives, and all configuration reads as zero. With that configuration, a unicast frame is rejected and a broadcast frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sof | input | 1 | Start-of-frame, high with the first address byte |
| byte_vld | input | 1 | Byte-valid qualifier for `byte_data` |
| byte_data | input | 8 | Destination address byte, first byte first |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| verdict_vld | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Accept flag, meaningful while `verdict_vld` is high |

## Verification
The only result this block produces is the verdict. It is due one clock edge after the sixth byte is taken: the edge that samples the sixth byte also registers the strobe, so it is visible in the following cycle. The driver pushes each expected verdict with the cycle number in which it is due. The monitor samples on the falling edge and checks both the accept value and the cycle. Any strobe with nothing queued is counted as an error, which covers short frames, trailing bytes and double strobes. The expected value is fixed from the bench's own configuration model when a frame starts, so a mid-frame write must not change it.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int MAC_W      = 8 * ADDR_BYTES;
  localparam int HIDX_W     = 6;
  localparam int HBINS      = 1 << HIDX_W;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  typedef struct packed {
    logic rx_all;     // bit 4
    logic bcast_dis;  // bit 3
    logic hash_mc;    // bit 2
    logic pass_mc;    // bit 1
    logic promisc;    // bit 0
  } mode_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  // Complement, reverse 32 bits, keep top HIDX_W bits.
  function automatic logic [HIDX_W-1:0] hash_index(input logic [31:0] crc);
    logic [HIDX_W-1:0] idx;
    for (int i = 0; i < HIDX_W; i++)
      idx[HIDX_W-1-i] = ~crc[i];
    return idx;
  endfunction
endpackage

// File: rtl/rxf_hash_crc.sv
module rxf_hash_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        take,
  input  logic [7:0]  din,
  output logic [31:0] crc_next
);
  import rxf_pkg::*;
  logic [31:0] crc_q;

  always_comb crc_next = crc_step(start ? 32'hFFFF_FFFF : crc_q, din);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    crc_q <= 32'hFFFF_FFFF;
    else if (take) crc_q <= crc_next;
endmodule

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs #(
  parameter int NUM_SLOTS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [5:0]                 addr,
  input  logic [31:0]                wdata,
  input  logic                       snap_load,
  output rxf_pkg::mode_t             snap_mode,
  output logic [rxf_pkg::HBINS-1:0]  snap_hash,
  output logic [NUM_SLOTS-1:0]       snap_en,
  output logic [NUM_SLOTS*rxf_pkg::MAC_W-1:0] slots_flat
);
  import rxf_pkg::*;
  localparam logic [5:0] A_MODE = 6'd0;
  localparam logic [5:0] A_HLO  = 6'd1;
  localparam logic [5:0] A_HHI  = 6'd2;
  localparam logic [5:0] A_EN   = 6'd3;
  localparam int         SLOT_BASE = 32;

  mode_t                 mode_q, mode_d;
  logic [HBINS-1:0]      hash_q, hash_d;
  logic [NUM_SLOTS-1:0]  en_q, en_d;

  always_comb begin
    mode_d = mode_q;
    hash_d = hash_q;
    en_d   = en_q;
    if (we) begin
      if (addr == A_MODE) mode_d = mode_t'(wdata[4:0]);
      if (addr == A_HLO)  hash_d[31:0]  = wdata;
      if (addr == A_HHI)  hash_d[63:32] = wdata;
      if (addr == A_EN)   en_d = wdata[NUM_SLOTS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= '0;
      hash_q <= '0;
      en_q   <= '0;
    end else begin
      mode_q <= mode_d;
      hash_q <= hash_d;
      en_q   <= en_d;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      snap_mode <= '0;
      snap_hash <= '0;
      snap_en   <= '0;
    end else if (snap_load) begin
      snap_mode <= mode_q;
      snap_hash <= hash_q;
      snap_en   <= en_q;
    end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [5:0] A_LO = 6'(SLOT_BASE + 2*k);
    localparam logic [5:0] A_HI = 6'(SLOT_BASE + 2*k + 1);
    logic [MAC_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) slot_q <= '0;
      else if (we && addr == A_LO) slot_q[31:0]  <= wdata;
      else if (we && addr == A_HI) slot_q[47:32] <= wdata[15:0];
    assign slots_flat[k*MAC_W +: MAC_W] = slot_q;
  end

  // R10: snapshot only moves when a frame opens
  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_load |=> ($stable(snap_mode) && $stable(snap_hash) && $stable(snap_en)));
endmodule

// File: rtl/rxf_ucast_match.sv
module rxf_ucast_match #(
  parameter int NUM_SLOTS = 16
) (
  input  logic [rxf_pkg::MAC_W-1:0]           addr,
  input  logic [NUM_SLOTS*rxf_pkg::MAC_W-1:0] slots_flat,
  input  logic [NUM_SLOTS-1:0]                en,
  output logic                                hit
);
  import rxf_pkg::*;
  logic [NUM_SLOTS-1:0] eq;
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
    assign eq[k] = en[k] && (slots_flat[k*MAC_W +: MAC_W] == addr);
  end
  assign hit = |eq;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int NUM_SLOTS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sof,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        verdict_vld,
  output logic        verdict_accept
);
  import rxf_pkg::*;
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
  localparam int HOLD_W = MAC_W - 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_i = rs_q[1];

  logic [CNT_W-1:0]  cnt_q, cnt_d, idx;
  logic [HOLD_W-1:0] addr_q, addr_d;
  logic              take, last, start;
  logic [31:0]       crc_next;
  mode_t             s_mode;
  logic [HBINS-1:0]  s_hash;
  logic [NUM_SLOTS-1:0] s_en;
  logic [NUM_SLOTS*MAC_W-1:0] slots_flat;
  logic [MAC_W-1:0]  full_addr;
  logic              uc_hit, is_bc, is_mc, hbit, acc;
  logic [HIDX_W-1:0] hidx;
  logic              vld_q, acc_q;

  assign start = byte_vld && sof;
  assign take  = start || (byte_vld && cnt_q != '0 && cnt_q < CNT_FULL);
  assign last  = byte_vld && !sof && cnt_q == CNT_LAST;
  assign idx   = start ? '0 : cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    if (start)     cnt_d = CNT_ONE;
    else if (take) cnt_d = cnt_q + CNT_ONE;
    for (int k = 0; k < ADDR_BYTES - 1; k++)
      if (take && idx == CNT_W'(k)) addr_d[8*k +: 8] = byte_data;
  end

  always_ff @(posedge clk or negedge rst_i)
    if (!rst_i) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end

  rxf_hash_crc u_crc (
    .clk(clk), .rst_n(rst_i), .start(start), .take(take),
    .din(byte_data), .crc_next(crc_next)
  );

  rxf_cfg_regs #(.NUM_SLOTS(NUM_SLOTS)) u_cfg (
    .clk(clk), .rst_n(rst_i), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .snap_load(start), .snap_mode(s_mode), .snap_hash(s_hash), .snap_en(s_en),
    .slots_flat(slots_flat)
  );

  assign full_addr = {byte_data, addr_q};

  rxf_ucast_match #(.NUM_SLOTS(NUM_SLOTS)) u_uc (
    .addr(full_addr), .slots_flat(slots_flat), .en(s_en), .hit(uc_hit)
  );

  always_comb begin
    is_bc = &full_addr;
    is_mc = full_addr[0];
    hidx  = hash_index(crc_next);
    hbit  = s_hash[hidx];
    if (s_mode.rx_all || s_mode.promisc) acc = 1'b1;
    else if (is_bc)                      acc = !s_mode.bcast_dis;
    else if (is_mc)                      acc = s_mode.pass_mc || (s_mode.hash_mc && hbit);
    else                                 acc = uc_hit;
  end

  always_ff @(posedge clk or negedge rst_i)
    if (!rst_i) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= last;
      acc_q <= last && acc;
    end

  assign verdict_vld    = vld_q;
  assign verdict_accept = acc_q;

  // R9: single-cycle strobe, due right after the sixth byte
  p_one_shot_r9: assert property (@(posedge clk) disable iff (!rst_i)
    verdict_vld |=> !verdict_vld);
  p_due_sixth_r9: assert property (@(posedge clk) disable iff (!rst_i)
    verdict_vld |-> ($past(byte_vld) && $past(cnt_q) == CNT_LAST));
  // R11: byte count never runs past the address length
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_i)
    cnt_q <= CNT_FULL);
  // R4: promiscuous frames always pass
  p_promisc_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (verdict_vld && s_mode.promisc) |-> verdict_accept);
  // R6: receive-all frames always pass
  p_rx_all_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (verdict_vld && s_mode.rx_all) |-> verdict_accept);
endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 1'b0, byte_vld = 1'b0, cfg_we = 1'b0;
  logic [7:0] byte_data = '0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic verdict_vld, verdict_accept;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .byte_data(byte_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .verdict_vld(verdict_vld), .verdict_accept(verdict_accept)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { bit acc; int due; string req; } exp_t;
  exp_t q[$];

  // configuration model
  logic [4:0]  m_mode = '0;
  logic [63:0] m_hash = '0;
  logic [15:0] m_en = '0;
  logic [47:0] m_slot [16];
  initial for (int k = 0; k < 16; k++) m_slot[k] = '0;

  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] c, r;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      c ^= {24'd0, a[8*b +: 8]};
      for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    c = ~c;
    for (int i = 0; i < 32; i++) r[31-i] = c[i];
    return r[31:26];
  endfunction

  function automatic bit model_verdict(input logic [47:0] a);
    if (m_mode[4] || m_mode[0]) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return !m_mode[3];
    if (a[0]) return m_mode[1] || (m_mode[2] && m_hash[ref_index(a)]);
    for (int k = 0; k < 16; k++) if (m_en[k] && m_slot[k] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic model_wr(input logic [5:0] a, input logic [31:0] d);
    if (a == 0) m_mode = d[4:0];
    if (a == 1) m_hash[31:0] = d;
    if (a == 2) m_hash[63:32] = d;
    if (a == 3) m_en = d[15:0];
    if (a >= 32) begin
      if (a[0]) m_slot[(a-32)/2][47:32] = d[15:0];
      else      m_slot[(a-32)/2][31:0]  = d;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_slot(input int k, input logic [47:0] a);
    wr(6'(32 + 2*k), a[31:0]);
    wr(6'(33 + 2*k), {16'd0, a[47:32]});
  endtask

  // driver: pushes the expected verdict when the sixth byte goes out
  task automatic send(input logic [47:0] a, input int nbytes, input int gap, input string req,
                      input bit mid_wr = 1'b0, input logic [5:0] wa = '0, input logic [31:0] wd = '0);
    bit e;
    e = model_verdict(a);
    for (int k = 0; k < nbytes; k++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      if (gap > 0 && k > 0) begin
        byte_vld = 1'b0; sof = 1'b0;
        repeat (gap) @(negedge clk);
      end
      byte_vld = 1'b1;
      sof = (k == 0);
      byte_data = (k < 6) ? a[8*k +: 8] : 8'h5A;
      if (mid_wr && k == 2) begin
        cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd; model_wr(wa, wd);
      end
      if (k == 5) q.push_back('{e, cyc + 1, req});
    end
    @(negedge clk);
    byte_vld = 1'b0; sof = 1'b0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && verdict_vld) begin
      if (q.size() == 0) check(1'b0, "R9/R11", "unexpected verdict", 1, 0);
      else begin
        exp_t x;
        x = q.pop_front();
        check(verdict_accept == x.acc, x.req, "accept", int'(verdict_accept), int'(x.acc));
        check(cyc == x.due, x.req, "verdict cycle", cyc, x.due);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WATCHDOG", "timeout", cyc, 0);
    finish_run();
  end

  localparam logic [47:0] UC_A = 48'h5544_3322_1102;
  localparam logic [47:0] UC_B = 48'h0A0B_0C0D_0E10;
  localparam logic [47:0] MC_A = 48'h0100_005E_0001;
  localparam logic [47:0] MC_B = 48'h3300_0000_0133;
  localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;

  initial begin
    logic [5:0] ix;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R12: idle after reset
    check(verdict_vld == 1'b0 && verdict_accept == 1'b0, "R12", "idle outputs", int'(verdict_vld), 0);
    send(UC_A, 6, 0, "R12");     // reject, nothing enabled
    send(BC, 6, 0, "R12");       // broadcast accepted by default

    // R5 unicast slots
    set_slot(0, UC_A);
    send(UC_A, 6, 0, "R5");      // slot loaded but disabled: reject
    wr(6'd3, 32'h0000_8001);
    set_slot(15, UC_B);
    send(UC_A, 6, 1, "R5");
    send(UC_B, 6, 0, "R5");
    send(UC_A ^ 48'h0100_0000_0000, 6, 0, "R5");
    wr(6'd3, 32'h0000_8000);
    send(UC_A, 6, 0, "R5");

    // R7 broadcast
    wr(6'd0, 32'h08);
    send(BC, 6, 0, "R7");
    wr(6'd0, 32'h0A);
    send(BC, 6, 0, "R7");
    wr(6'd0, 32'h09);
    send(BC, 6, 0, "R7");

    // R8 multicast without modes
    wr(6'd0, 32'h00);
    send(MC_A, 6, 0, "R8");
    // R3 pass all multicast
    wr(6'd1, 32'h0); wr(6'd2, 32'h0);
    wr(6'd0, 32'h02);
    send(MC_A, 6, 0, "R3");
    send(MC_B, 6, 2, "R3");

    // R1/R2 hash lookup and word selection
    wr(6'd0, 32'h04);
    send(MC_A, 6, 0, "R2");      // empty table: reject
    ix = ref_index(MC_A);
    if (ix[5]) wr(6'd2, 32'(1) << ix[4:0]);
    else       wr(6'd1, 32'(1) << ix[4:0]);
    send(MC_A, 6, 0, "R1");      // accept
    send(MC_B, 6, 0, "R2");      // model decides
    wr(6'd1, 32'h0); wr(6'd2, 32'h0);
    if (ix[5]) wr(6'd1, 32'(1) << ix[4:0]);
    else       wr(6'd2, 32'(1) << ix[4:0]);
    send(MC_A, 6, 0, "R1");      // wrong word: reject

    // R4 promiscuous, R6 receive all
    wr(6'd0, 32'h01);
    send(48'h1234_5678_9ABC, 6, 0, "R4");
    wr(6'd0, 32'h10);
    send(48'h1234_5678_9AB8, 6, 1, "R6");

    // R10 mid-frame writes do not affect the open frame
    wr(6'd0, 32'h00);
    send(MC_A, 6, 0, "R10", 1'b1, 6'd0, 32'h01);   // reject despite promisc write
    send(MC_A, 6, 0, "R10");                       // now accepted
    wr(6'd0, 32'h00);

    // R11 short frame then full frame; R9 trailing bytes ignored
    send(BC, 4, 0, "R11");
    send(BC, 9, 0, "R9");
    send(UC_B, 8, 1, "R9");
    @(negedge clk);
    byte_vld = 1'b1; sof = 1'b0; byte_data = 8'hFF;   // R11: bytes with no open frame
    repeat (8) @(negedge clk);
    byte_vld = 1'b0;

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R9", "pending verdicts", q.size(), 0);
    finish_run();
  end
endmodule